// File: doc/BRIEF.md
# Selector Channel Program Fetch Sequencer

This block is the control sequencer of a selector-style I/O channel. A device controller raises a service request. The channel then takes that request and reserves itself for that one device until it is released. Next it asks the device for its number and forms a table address from it. It reads that table word from memory to seed an I/O program counter. It then fetches one program doubleword: a command word followed by an address word, each held in its own active register.

Every memory read uses a request/grant/strobe handshake with a port controller. The read request stays up until a grant arrives. The address appears on the port bus only in the grant cycle. A data strobe later returns the word. After each doubleword the block raises a one-cycle done pulse. It then waits for a next-fetch command, which fetches the following doubleword, or for a release, which frees the channel.

Top module: `sel_prog_fetch`

## Requirements
- R1: After reset: svcSel is zero, memReq, devNumAsk, fetchDone and protoErr are low, and memAddr is zero.
- R2: A request that arrives while idle reserves the channel for the lowest-numbered requesting device. From the next clock, svcSel holds a one-hot code for that device (bit i = device i).
- R3: While the channel is reserved, requests from any device leave svcSel unchanged.
- R4: For exactly one cycle after reservation, devNumAsk is high. The value on devNumIn in that cycle is latched as tableAddr = devNumIn shifted left by two, with zeros above.
- R5: memReq stays high from the start of an access until a cycle with memGrant high. memAddr is zero in every cycle without a grant, and memReq drops the cycle after the grant.
- R6: The first access of a session reads address tableAddr, and its strobed word is loaded into progCnt. No later access of the session uses tableAddr.
- R7: Each program fetch makes two reads, at progCnt and then progCnt+1 (modulo 2^16). The first strobed word is loaded into cmdWord and the second into addrWord.
- R8: progCnt advances by one on the clock edge that ends a program-fetch grant cycle, so the new value shows before the data strobe.
- R9: fetchDone is high for exactly one cycle after addrWord loads. A nextFetch pulse then starts a new doubleword fetch from the current progCnt.
- R10: A strobe that arrives while no read data is awaited changes none of progCnt, cmdWord and addrWord. It also sets protoErr, which stays high until reset.
- R11: chanRelease returns the sequencer to idle from any state. One clock later svcSel is zero and memReq is low, and a new request is then accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| devReq | input | DEVS | Service request, one bit per device |
| devNumIn | input | 8 | Device number from the owning controller |
| devNumAsk | output | 1 | Asks the owner for its device number |
| svcSel | output | DEVS | One-hot enable of the device allowed to answer service-out |
| chanRelease | input | 1 | Frees the channel and returns to idle |
| memReq | output | 1 | Read request to the port controller |
| memGrant | input | 1 | Port controller select/grant |
| memAddr | output | 16 | Read address, driven only in the grant cycle |
| memStrb | input | 1 | Read data strobe |
| memData | input | 16 | Read data |
| nextFetch | input | 1 | Start the next doubleword fetch |
| fetchDone | output | 1 | One-cycle pulse after each doubleword |
| progCnt | output | 16 | I/O program counter |
| cmdWord | output | 16 | Active command word |
| addrWord | output | 16 | Active address word |
| tableAddr | output | 16 | Latched table address |
| protoErr | output | 1 | Sticky unexpected-strobe flag |

## Verification
Some results are combinational on the current state and inputs: memAddr in a grant cycle, devNumAsk, and a request held without a grant. The bench drives each stimulus at the falling edge and checks these 1 ns later. Results that pass through a register show up at the falling edge after the next rising edge. These are svcSel after a request, tableAddr, progCnt after a grant or strobe, the active words, the done pulse, protoErr, and the idle state after a release. The bench checks them one half-cycle after that rising edge. The memory model holds each grant and strobe for exactly one cycle, so every expected value belongs to one known clock edge.

// File: rtl/selfetch_pkg.sv
package selfetch_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DEVNUM,
    S_TBL_REQ,
    S_TBL_WAIT,
    S_CW_REQ,
    S_CW_WAIT,
    S_AW_REQ,
    S_AW_WAIT,
    S_DONE
  } seqState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic ldOwner;
    logic clrOwner;
    logic ldTable;
    logic sendTable;
    logic sendPc;
    logic ldPc;
    logic ldCw;
    logic ldAw;
  } dpCtl_t;

endpackage

// File: rtl/sel_fetch_ctrl.sv
module sel_fetch_ctrl
  import selfetch_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   anyReq,
  input  logic   memGrant,
  input  logic   memStrb,
  input  logic   nextFetch,
  input  logic   chanRelease,
  output dpCtl_t ctl,
  output logic   memReq,
  output logic   devNumAsk,
  output logic   fetchDone,
  output logic   protoErr
);

  seqState_t state, nextSt;
  logic doneSeen;
  logic waiting;

  always_comb begin
    nextSt = state;
    unique case (state)
      S_IDLE:     if (anyReq)    nextSt = S_DEVNUM;
      S_DEVNUM:                  nextSt = S_TBL_REQ;
      S_TBL_REQ:  if (memGrant)  nextSt = S_TBL_WAIT;
      S_TBL_WAIT: if (memStrb)   nextSt = S_CW_REQ;
      S_CW_REQ:   if (memGrant)  nextSt = S_CW_WAIT;
      S_CW_WAIT:  if (memStrb)   nextSt = S_AW_REQ;
      S_AW_REQ:   if (memGrant)  nextSt = S_AW_WAIT;
      S_AW_WAIT:  if (memStrb)   nextSt = S_DONE;
      S_DONE:     if (nextFetch) nextSt = S_CW_REQ;
      default:                   nextSt = S_IDLE;
    endcase
    if (chanRelease) nextSt = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      doneSeen <= 1'b0;
      protoErr <= 1'b0;
    end else begin
      state    <= nextSt;
      doneSeen <= (state == S_DONE);
      protoErr <= protoErr | (memStrb & ~waiting);
    end
  end

  assign waiting   = (state == S_TBL_WAIT) || (state == S_CW_WAIT) || (state == S_AW_WAIT);
  assign memReq    = (state == S_TBL_REQ) || (state == S_CW_REQ) || (state == S_AW_REQ);
  assign devNumAsk = (state == S_DEVNUM);
  assign fetchDone = (state == S_DONE) && !doneSeen;

  always_comb begin
    ctl           = '0;
    ctl.ldOwner   = (state == S_IDLE) && anyReq && !chanRelease;
    ctl.clrOwner  = chanRelease;
    ctl.ldTable   = (state == S_DEVNUM);
    ctl.sendTable = (state == S_TBL_REQ) && memGrant;
    ctl.sendPc    = ((state == S_CW_REQ) || (state == S_AW_REQ)) && memGrant;
    ctl.ldPc      = (state == S_TBL_WAIT) && memStrb;
    ctl.ldCw      = (state == S_CW_WAIT) && memStrb;
    ctl.ldAw      = (state == S_AW_WAIT) && memStrb;
  end

endmodule

// File: rtl/sel_fetch_dpath.sv
module sel_fetch_dpath
  import selfetch_pkg::*;
#(
  parameter int DEVS   = 4,
  parameter int WORD_W = 16,
  parameter int DNUM_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [DEVS-1:0]   devReq,
  input  logic [DNUM_W-1:0] devNumIn,
  input  logic [WORD_W-1:0] memData,
  output logic [DEVS-1:0]   svcSel,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] progCnt,
  output logic [WORD_W-1:0] cmdWord,
  output logic [WORD_W-1:0] addrWord,
  output logic [WORD_W-1:0] tableAddr
);

  localparam int TA_W = DNUM_W + 2;
  localparam int PAD_W = WORD_W - TA_W;

  logic [DEVS-1:0] pick;

  // lowest-numbered requester wins
  always_comb begin
    pick = '0;
    for (int i = DEVS - 1; i >= 0; i--) begin
      if (devReq[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      svcSel    <= '0;
      progCnt   <= '0;
      cmdWord   <= '0;
      addrWord  <= '0;
      tableAddr <= '0;
    end else begin
      if (ctl.clrOwner)     svcSel <= '0;
      else if (ctl.ldOwner) svcSel <= pick;
      if (ctl.ldTable) tableAddr <= {{PAD_W{1'b0}}, devNumIn, 2'b00};
      if (ctl.ldPc)        progCnt <= memData;
      else if (ctl.sendPc) progCnt <= progCnt + WORD_W'(1);
      if (ctl.ldCw) cmdWord  <= memData;
      if (ctl.ldAw) addrWord <= memData;
    end
  end

  assign memAddr = ctl.sendTable ? tableAddr :
                   ctl.sendPc    ? progCnt   : '0;

endmodule

// File: rtl/sel_prog_fetch.sv
module sel_prog_fetch
  import selfetch_pkg::*;
#(
  parameter int DEVS   = 4,
  parameter int WORD_W = 16,
  parameter int DNUM_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DEVS-1:0]   devReq,
  input  logic [DNUM_W-1:0] devNumIn,
  output logic              devNumAsk,
  output logic [DEVS-1:0]   svcSel,
  input  logic              chanRelease,
  output logic              memReq,
  input  logic              memGrant,
  output logic [WORD_W-1:0] memAddr,
  input  logic              memStrb,
  input  logic [WORD_W-1:0] memData,
  input  logic              nextFetch,
  output logic              fetchDone,
  output logic [WORD_W-1:0] progCnt,
  output logic [WORD_W-1:0] cmdWord,
  output logic [WORD_W-1:0] addrWord,
  output logic [WORD_W-1:0] tableAddr,
  output logic              protoErr
);

  dpCtl_t ctl;

  sel_fetch_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .anyReq(|devReq), .memGrant(memGrant),
    .memStrb(memStrb), .nextFetch(nextFetch), .chanRelease(chanRelease),
    .ctl(ctl), .memReq(memReq), .devNumAsk(devNumAsk),
    .fetchDone(fetchDone), .protoErr(protoErr)
  );

  sel_fetch_dpath #(.DEVS(DEVS), .WORD_W(WORD_W), .DNUM_W(DNUM_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .devReq(devReq), .devNumIn(devNumIn),
    .memData(memData), .svcSel(svcSel), .memAddr(memAddr), .progCnt(progCnt),
    .cmdWord(cmdWord), .addrWord(addrWord), .tableAddr(tableAddr)
  );

endmodule

// File: rtl/sel_fetch_chk.sv
module sel_fetch_chk #(
  parameter int DEVS   = 4,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [DEVS-1:0]   svcSel,
  input logic              chanRelease,
  input logic              memReq,
  input logic              memGrant,
  input logic [WORD_W-1:0] memAddr,
  input logic              fetchDone,
  input logic              protoErr
);

  AST_SVC_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(svcSel)); // R2

  AST_SVC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (svcSel != '0 && !chanRelease) |=> $stable(svcSel)); // R3

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGrant && !chanRelease) |=> memReq); // R5

  AST_ADDR_GRANT_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (memAddr != '0) |-> (memReq && memGrant)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    fetchDone |=> !fetchDone); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr); // R10

  AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    chanRelease |=> (svcSel == '0 && !memReq)); // R11

endmodule

bind sel_prog_fetch sel_fetch_chk #(.DEVS(DEVS), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .svcSel(svcSel), .chanRelease(chanRelease),
  .memReq(memReq), .memGrant(memGrant), .memAddr(memAddr),
  .fetchDone(fetchDone), .protoErr(protoErr)
);

// File: tb/tb_sel_prog_fetch.sv
module tb_sel_prog_fetch;

  localparam int DEVS = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DEVS-1:0] devReq = '0;
  logic [7:0]  devNumIn = '0;
  logic        devNumAsk;
  logic [DEVS-1:0] svcSel;
  logic        chanRelease = 1'b0;
  logic        memReq;
  logic        memGrant = 1'b0;
  logic [15:0] memAddr;
  logic        memStrb = 1'b0;
  logic [15:0] memData = '0;
  logic        nextFetch = 1'b0;
  logic        fetchDone;
  logic [15:0] progCnt, cmdWord, addrWord, tableAddr;
  logic        protoErr;

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  sel_prog_fetch dut (
    .clk(clk), .rstN(rstN), .devReq(devReq), .devNumIn(devNumIn),
    .devNumAsk(devNumAsk), .svcSel(svcSel), .chanRelease(chanRelease),
    .memReq(memReq), .memGrant(memGrant), .memAddr(memAddr),
    .memStrb(memStrb), .memData(memData), .nextFetch(nextFetch),
    .fetchDone(fetchDone), .progCnt(progCnt), .cmdWord(cmdWord),
    .addrWord(addrWord), .tableAddr(tableAddr), .protoErr(protoErr)
  );

  // {request, devNum, table word, command word, address word}
  localparam logic [59:0] VEC [4] = '{
    {4'b0001, 8'h05, 16'h1200, 16'hA001, 16'h3000},
    {4'b0110, 8'hFF, 16'hFFFE, 16'h0F0F, 16'hC3C3},
    {4'b1000, 8'h00, 16'h0040, 16'h1234, 16'h5678},
    {4'b1111, 8'h80, 16'h7FFF, 16'hFFFF, 16'h0000}
  };

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DEVS-1:0] lowest(input logic [DEVS-1:0] r);
    for (int i = 0; i < DEVS; i++) if (r[i]) return DEVS'(1) << i;
    return '0;
  endfunction

  // one read: optional grant delay, grant, strobe
  task automatic memXact(input logic [15:0] expAddr, input logic [15:0] word,
                         input int waitCyc, input bit chkInc, input logic [15:0] expPc,
                         input string tag);
    for (int i = 0; i < waitCyc; i++) begin
      @(negedge clk); #1;
      chk(memReq === 1'b1 && memAddr === 16'h0, "R5 request held without grant", {memReq, memAddr}, {1'b1, 16'h0});
    end
    @(negedge clk); memGrant = 1'b1; #1;
    chk(memAddr === expAddr, tag, memAddr, expAddr);
    @(negedge clk); memGrant = 1'b0; #1;
    chk(memReq === 1'b0 && memAddr === 16'h0, "R5 request drops after grant", {memReq, memAddr}, 0);
    if (chkInc) chk(progCnt === expPc, "R8 counter advanced at grant", progCnt, expPc);
    memStrb = 1'b1; memData = word;
    @(negedge clk); memStrb = 1'b0; memData = '0;
  endtask

  task automatic fetchPair(input logic [15:0] pc, input logic [15:0] cw, input logic [15:0] aw);
    memXact(pc, cw, 0, 1, pc + 16'd1, "R7 command word address");
    memXact(pc + 16'd1, aw, 0, 1, pc + 16'd2, "R7 address word address");
    #1;
    chk(fetchDone === 1'b1, "R9 done pulse", fetchDone, 1);
    chk(cmdWord === cw, "R7 command word", cmdWord, cw);
    chk(addrWord === aw, "R7 address word", addrWord, aw);
    chk(progCnt === pc + 16'd2, "R8 counter after pair", progCnt, pc + 16'd2);
    @(negedge clk); #1;
    chk(fetchDone === 1'b0, "R9 done lasts one cycle", fetchDone, 0);
  endtask

  task automatic startSession(input logic [DEVS-1:0] req, input logic [7:0] dn);
    @(negedge clk); devReq = req;
    @(negedge clk); devReq = '0; devNumIn = dn; #1;
    chk(devNumAsk === 1'b1, "R4 device number asked", devNumAsk, 1);
    chk(svcSel === lowest(req), "R2 lowest requester reserved", svcSel, lowest(req));
  endtask

  task automatic releaseChan();
    @(negedge clk); chanRelease = 1'b1;
    @(negedge clk); chanRelease = 1'b0; #1;
    chk(svcSel === '0 && memReq === 1'b0, "R11 release to idle", {svcSel, memReq}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [59:0] v;
    logic [15:0] pcNow;
    // R1 reset state
    repeat (3) @(negedge clk);
    rstN = 1'b1; #1;
    chk(svcSel === '0 && memReq === 1'b0 && devNumAsk === 1'b0 && fetchDone === 1'b0
        && protoErr === 1'b0 && memAddr === 16'h0, "R1 reset state",
        {svcSel, memReq, devNumAsk, fetchDone, protoErr, memAddr}, 0);

    // vector walk: full session per entry, grant delayed by i cycles
    for (int i = 0; i < 4; i++) begin
      v = VEC[i];
      startSession(v[59:56], v[55:48]);
      memXact({6'b0, v[55:48], 2'b00}, v[47:32], i, 0, 16'h0, "R6 table address used");
      chk(tableAddr === {6'b0, v[55:48], 2'b00}, "R4 table address latched", tableAddr, {6'b0, v[55:48], 2'b00});
      chk(progCnt === v[47:32], "R6 counter seeded", progCnt, v[47:32]);
      fetchPair(v[47:32], v[31:16], v[15:0]);
      releaseChan();
    end

    // R3 foreign requests while reserved
    startSession(4'b0100, 8'h10);
    devReq = 4'b0011;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); #1;
      chk(svcSel === 4'b0100, "R3 reservation unchanged", svcSel, 4'b0100);
    end
    devReq = '0;
    memXact(16'h0040, 16'h0100, 0, 0, 16'h0, "R6 table address used");
    fetchPair(16'h0100, 16'h1111, 16'h2222);
    chk(svcSel === 4'b0100, "R3 reservation after fetch", svcSel, 4'b0100);

    // R9 next fetch continues from counter
    @(negedge clk); nextFetch = 1'b1;
    @(negedge clk); nextFetch = 1'b0;
    fetchPair(16'h0102, 16'h3333, 16'h4444);

    // R10 stray strobe while nothing awaited
    @(negedge clk); #1;
    chk(protoErr === 1'b0, "R10 no error yet", protoErr, 0);
    memStrb = 1'b1; memData = 16'hDEAD;
    @(negedge clk); memStrb = 1'b0; memData = '0; #1;
    chk(protoErr === 1'b1, "R10 error set", protoErr, 1);
    chk(progCnt === 16'h0104 && cmdWord === 16'h3333 && addrWord === 16'h4444,
        "R10 registers untouched", {progCnt, cmdWord}, {16'h0104, 16'h3333});
    @(negedge clk); #1;
    chk(protoErr === 1'b1, "R10 error sticky", protoErr, 1);

    // R11 release in the middle of a read
    @(negedge clk); nextFetch = 1'b1;
    @(negedge clk); nextFetch = 1'b0;
    @(negedge clk); memGrant = 1'b1;
    @(negedge clk); memGrant = 1'b0;
    pcNow = progCnt;
    chk(pcNow === 16'h0105, "R8 counter advanced before release", pcNow, 16'h0105);
    releaseChan();
    @(negedge clk); #1;
    chk(memReq === 1'b0 && devNumAsk === 1'b0, "R11 stays idle", {memReq, devNumAsk}, 0);
    startSession(4'b0010, 8'h01);
    memXact(16'h0004, 16'h0500, 0, 0, 16'h0, "R11 new session table address");
    fetchPair(16'h0500, 16'hABCD, 16'h0123);
    releaseChan();

    // R1 reset clears the sticky flag
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1; #1;
    chk(protoErr === 1'b0 && svcSel === '0, "R1 reset clears error", {protoErr, svcSel}, 0);

    finishRun();
  end

endmodule